// File: doc/BRIEF.md
# Block Exponent Assigner with Delay-Line Rescale

This block sits in front of a block-floating-point adaptive filter. It takes a stream of input samples and desired-response samples, both fixed-point fractions, and groups them into non-overlapping blocks of `N` accepted samples. For every block it finds the largest magnitude over both streams and turns it into a max exponent. From that exponent and the previous block's one it picks a shared block exponent and a scaling factor. The scaling factor grows when a block is quieter than the one before it, so the delay line of the filter can carry a single exponent across the block boundary.

When the last sample of a block is accepted, the block registers its results for that block. These are the block exponent, its signed change from the previous block, the scaling factor, the larger of the current and previous max exponents, and a flag that says which of the two won. The block keeps the last `L-1` input mantissas of the previous block, formatted with that block's exponent. It shifts them by the exponent change to give the history the filter uses, and by the change minus the minimum scaling to give a second copy that the weight-update path uses. It then stores the tail of the new block, formatted with the new exponent, for the next boundary. All results hold until the next block completes.

Samples are signed `W`-bit fractions (sign bit, then `W-1` fraction bits). Exponents are signed `EW`-bit values, and the exponent change and the scaling factor are `EW+1` bits wide. The minimum scaling `SMIN` equals ceil(log2 `L`).

Top module: `bexp_assigner`

## Requirements
- R1: While reset is asserted and after it is released, before any block completes, `blk_valid` is 0 and every other output is 0.
- R2: `blk_valid` is high for one cycle, in the cycle after the clock edge that accepts the `N`th sample of a block. Only cycles with `in_valid` high count as samples, and idle cycles between samples neither count nor end the block.
- R3: `blk_ex` equals floor(log2 M)+1, where M is the largest of |x|/2^(W-1) and |d|/2^(W-1) over all samples of the block. A block whose samples are all zero gives -(W-1).
- R4: The first block after reset is compared against its own max exponent. It reports scale `SMIN`, gamma = ex + `SMIN`, delta 0 and `blk_cur_ge` 1.
- R5: When ex of the block is at least ex of the previous block, the block reports scale = `SMIN`, gamma = ex + `SMIN`, `blk_exmax` = ex and `blk_cur_ge` = 1.
- R6: When ex of the block is below ex of the previous block, the block reports scale = ex_prev - ex + `SMIN`, gamma = ex_prev + `SMIN`, `blk_exmax` = ex_prev and `blk_cur_ge` = 0.
- R7: `blk_delta` is the two's-complement value gamma of this block minus gamma of the previous block.
- R8: Field k of `hist_filt` (bits [(k+1)*W-1 : k*W], k = 0 for the newest sample) is the previous block's input sample at k+1 positions before the block boundary. That sample is first shifted arithmetically right by the previous gamma (left if that gamma is negative). The result is then shifted right by delta when delta is positive, or left by |delta| when delta is negative.
- R9: Field k of `hist_upd` is the same stored mantissa as in R8, shifted right by (delta - `SMIN`), or left by its magnitude when that amount is negative.
- R10: Between two `blk_valid` pulses every registered output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample pair is presented this cycle |
| x_in | input | W | Input sample, signed fraction |
| d_in | input | W | Desired-response sample, signed fraction |
| blk_valid | output | 1 | One-cycle pulse when a block's results are updated |
| blk_ex | output | EW | Max exponent of the completed block |
| blk_gamma | output | EW | Block exponent |
| blk_delta | output | EW+1 | Block exponent minus previous block exponent |
| blk_scale | output | EW+1 | Scaling factor chosen for the block (unsigned) |
| blk_exmax | output | EW | Larger of current and previous max exponent |
| blk_cur_ge | output | 1 | 1 when the current max exponent is not below the previous one |
| hist_filt | output | (L-1)*W | Carried-over history mantissas rescaled by delta |
| hist_upd | output | (L-1)*W | Same history shifted by delta minus SMIN |

## Verification
The checker assumes that the parameters keep every block exponent inside `EW` signed bits. It also assumes that `N` is at least `L-1`, so the stored tail comes entirely from one block. Its scale and delta properties rely on the previous block's values. That holds because `blk_valid` can only follow an accepted last sample. The stimulus uses `W`=8, `L`=4 and `N`=4, with peaks from zero up to full-scale negative. This keeps gamma between -2 and 3 and keeps every left shift of a stored mantissa inside eight bits, so the bench model never has to allow for wrap-around.

// File: rtl/bexp_pkg.sv
package bexp_pkg;

  // How the block exponent of the current block was derived.
  typedef enum logic [1:0] {
    STEP_FIRST = 2'd0,
    STEP_UP    = 2'd1,
    STEP_QUIET = 2'd2
  } step_e;

  // Position of the highest set bit, -1 for zero.
  function automatic int top_bit(input logic [31:0] m);
    int pos;
    pos = -1;
    for (int b = 0; b < 32; b++) begin
      if (m[b]) pos = b;
    end
    return pos;
  endfunction

  // Signed shift: right (arithmetic) for a non-negative amount, left otherwise.
  function automatic logic signed [31:0] shift_by(input logic signed [31:0] v,
                                                  input int sh);
    if (sh >= 0) return v >>> sh;
    else         return v <<< (-sh);
  endfunction

endpackage

// File: rtl/bexp_collect.sv
module bexp_collect
  import bexp_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 4,
  parameter int L = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  d_in,
  output logic                 take,
  output logic [W-1:0]         peak,
  output logic [(L-1)*W-1:0]   tail_next
);
  localparam int CW = $clog2(N + 1);
  localparam int HL = L - 1;

  logic [CW-1:0]     cnt_q;
  logic [W-1:0]      run_max_q;
  logic [HL*W-1:0]   tail_q;
  logic [W-1:0]      x_mag;
  logic [W-1:0]      d_mag;

  // Magnitudes; the most negative code maps to 2^(W-1) as unsigned.
  always_comb begin
    x_mag = x_in[W-1] ? W'(-x_in) : W'(x_in);
    d_mag = d_in[W-1] ? W'(-d_in) : W'(d_in);
  end

  // Running peak including the sample offered this cycle.
  always_comb begin
    peak = run_max_q;
    if (in_valid) begin
      if (x_mag > peak) peak = x_mag;
      if (d_mag > peak) peak = d_mag;
    end
  end

  assign take = in_valid && (cnt_q == CW'(N - 1));

  // Tail of input samples, index 0 is the newest.
  always_comb begin
    tail_next = tail_q;
    if (in_valid) begin
      tail_next[W-1:0] = x_in;
      for (int k = 1; k < HL; k++) begin
        tail_next[k*W +: W] = tail_q[(k-1)*W +: W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      run_max_q <= '0;
      tail_q    <= '0;
    end else begin
      tail_q <= tail_next;
      if (in_valid) begin
        cnt_q     <= take ? '0 : cnt_q + CW'(1);
        run_max_q <= take ? '0 : peak;
      end
    end
  end

endmodule

// File: rtl/bexp_lead.sv
module bexp_lead
  import bexp_pkg::*;
#(
  parameter int W  = 8,
  parameter int EW = 4
) (
  input  logic [W-1:0]         mag,
  output logic signed [EW-1:0] ex
);
  localparam int EXP_FLOOR = -(W - 1);

  // Fraction format: value = mag / 2^(W-1); ex = floor(log2 value) + 1.
  always_comb begin
    if (mag == '0) ex = EW'(EXP_FLOOR);
    else           ex = EW'(top_bit(32'(mag)) + 2 - W);
  end

endmodule

// File: rtl/bexp_assign.sv
module bexp_assign
  import bexp_pkg::*;
#(
  parameter int EW   = 4,
  parameter int SMIN = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic signed [EW-1:0]  ex_new,
  output logic signed [EW-1:0]  gam_next,
  output logic signed [EW:0]    delta_next,
  output logic [EW:0]           scale_next,
  output logic signed [EW-1:0]  exmax_next,
  output logic                  ge_next,
  output step_e                 kind
);
  logic                 first_q;
  logic signed [EW-1:0] ex_prev_q;
  logic signed [EW-1:0] gam_prev_q;

  always_comb begin
    int e_new, e_ref, g_new, g_ref, s_val, e_max;
    e_new = int'(ex_new);
    e_ref = first_q ? e_new : int'(ex_prev_q);
    if (e_new >= e_ref) begin
      g_new   = e_new + SMIN;
      s_val   = SMIN;
      e_max   = e_new;
      ge_next = 1'b1;
    end else begin
      g_new   = e_ref + SMIN;
      s_val   = e_ref - e_new + SMIN;
      e_max   = e_ref;
      ge_next = 1'b0;
    end
    g_ref      = first_q ? g_new : int'(gam_prev_q);
    gam_next   = EW'(g_new);
    delta_next = (EW+1)'(g_new - g_ref);
    scale_next = (EW+1)'(s_val);
    exmax_next = EW'(e_max);
    if (first_q)            kind = STEP_FIRST;
    else if (e_new >= e_ref) kind = STEP_UP;
    else                     kind = STEP_QUIET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q    <= 1'b1;
      ex_prev_q  <= '0;
      gam_prev_q <= '0;
    end else if (take) begin
      first_q    <= 1'b0;
      ex_prev_q  <= ex_new;
      gam_prev_q <= gam_next;
    end
  end

endmodule

// File: rtl/bexp_rescale.sv
module bexp_rescale
  import bexp_pkg::*;
#(
  parameter int W    = 8,
  parameter int L    = 4,
  parameter int SMIN = 2,
  parameter int DW   = 5
) (
  input  logic [(L-1)*W-1:0]   hist_in,
  input  logic signed [DW-1:0] delta,
  output logic [(L-1)*W-1:0]   filt,
  output logic [(L-1)*W-1:0]   upd
);
  localparam int HL = L - 1;

  for (genvar j = 0; j < HL; j++) begin : g_tap
    assign filt[j*W +: W] =
      W'(shift_by(32'(signed'(hist_in[j*W +: W])), int'(delta)));
    assign upd[j*W +: W]  =
      W'(shift_by(32'(signed'(hist_in[j*W +: W])), int'(delta) - SMIN));
  end

endmodule

// File: rtl/bexp_assigner.sv
module bexp_assigner
  import bexp_pkg::*;
#(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int L  = 4,
  parameter int EW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [W-1:0]        x_in,
  input  logic signed [W-1:0]        d_in,
  output logic                       blk_valid,
  output logic signed [EW-1:0]       blk_ex,
  output logic signed [EW-1:0]       blk_gamma,
  output logic signed [EW:0]         blk_delta,
  output logic [EW:0]                blk_scale,
  output logic signed [EW-1:0]       blk_exmax,
  output logic                       blk_cur_ge,
  output logic [(L-1)*W-1:0]         hist_filt,
  output logic [(L-1)*W-1:0]         hist_upd
);
  localparam int SMIN = $clog2(L);
  localparam int HL   = L - 1;
  localparam int DW   = EW + 1;

  // Named internal events, also observed by the bound checker.
  logic                  blk_take;
  logic [W-1:0]          blk_peak;
  logic [HL*W-1:0]       tail_next;
  logic signed [EW-1:0]  ex_new;
  logic signed [EW-1:0]  gam_next;
  logic signed [DW-1:0]  delta_next;
  logic [DW-1:0]         scale_next;
  logic signed [EW-1:0]  exmax_next;
  logic                  ge_next;
  step_e                 step_kind;
  logic [HL*W-1:0]       hist_mant_q;
  logic [HL*W-1:0]       filt_next;
  logic [HL*W-1:0]       upd_next;
  logic [HL*W-1:0]       store_next;

  bexp_collect #(.W(W), .N(N), .L(L)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x_in      (x_in),
    .d_in      (d_in),
    .take      (blk_take),
    .peak      (blk_peak),
    .tail_next (tail_next)
  );

  bexp_lead #(.W(W), .EW(EW)) u_lead (
    .mag (blk_peak),
    .ex  (ex_new)
  );

  bexp_assign #(.EW(EW), .SMIN(SMIN)) u_assign (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (blk_take),
    .ex_new     (ex_new),
    .gam_next   (gam_next),
    .delta_next (delta_next),
    .scale_next (scale_next),
    .exmax_next (exmax_next),
    .ge_next    (ge_next),
    .kind       (step_kind)
  );

  bexp_rescale #(.W(W), .L(L), .SMIN(SMIN), .DW(DW)) u_rescale (
    .hist_in (hist_mant_q),
    .delta   (delta_next),
    .filt    (filt_next),
    .upd     (upd_next)
  );

  // Tail of the finishing block, formatted with its own block exponent.
  for (genvar j = 0; j < HL; j++) begin : g_store
    assign store_next[j*W +: W] =
      W'(shift_by(32'(signed'(tail_next[j*W +: W])), int'(gam_next)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_valid   <= 1'b0;
      blk_ex      <= '0;
      blk_gamma   <= '0;
      blk_delta   <= '0;
      blk_scale   <= '0;
      blk_exmax   <= '0;
      blk_cur_ge  <= 1'b0;
      hist_filt   <= '0;
      hist_upd    <= '0;
      hist_mant_q <= '0;
    end else begin
      blk_valid <= blk_take;
      if (blk_take) begin
        blk_ex      <= ex_new;
        blk_gamma   <= gam_next;
        blk_delta   <= delta_next;
        blk_scale   <= scale_next;
        blk_exmax   <= exmax_next;
        blk_cur_ge  <= ge_next;
        hist_filt   <= filt_next;
        hist_upd    <= upd_next;
        hist_mant_q <= store_next;
      end
    end
  end

endmodule

// File: rtl/bexp_assigner_chk.sv
module bexp_assigner_chk
  import bexp_pkg::*;
#(
  parameter int EW   = 4,
  parameter int SMIN = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  take,
  input step_e                 kind,
  input logic                  blk_valid,
  input logic signed [EW-1:0]  blk_ex,
  input logic signed [EW-1:0]  blk_gamma,
  input logic signed [EW:0]    blk_delta,
  input logic [EW:0]           blk_scale,
  input logic signed [EW-1:0]  blk_exmax,
  input logic                  blk_cur_ge
);
  logic                 seen_q;
  logic signed [EW-1:0] prev_gam_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      prev_gam_q <= '0;
    end else if (blk_valid) begin
      seen_q     <= 1'b1;
      prev_gam_q <= blk_gamma;
    end
  end

  AST_PULSE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> blk_valid); // R2
  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> $past(take)); // R2
  AST_FIRST_DELTA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == STEP_FIRST) |=> (blk_delta == '0 && blk_cur_ge)); // R4
  AST_RISE_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_cur_ge) |-> (blk_scale == (EW+1)'(SMIN) && blk_exmax == blk_ex)); // R5
  AST_GAMMA_FROM_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (int'(blk_gamma) == int'(blk_exmax) + SMIN)); // R5
  AST_QUIET_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_cur_ge) |-> (blk_scale > (EW+1)'(SMIN) && blk_exmax > blk_ex)); // R6
  AST_DELTA_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && seen_q) |-> (int'(blk_delta) == int'(blk_gamma) - int'(prev_gam_q))); // R7
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |-> ($stable(blk_gamma) && $stable(blk_delta) && $stable(blk_scale)
                    && $stable(blk_ex) && $stable(blk_exmax))); // R10

endmodule

bind bexp_assigner bexp_assigner_chk #(.EW(EW), .SMIN(SMIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .take       (blk_take),
  .kind       (step_kind),
  .blk_valid  (blk_valid),
  .blk_ex     (blk_ex),
  .blk_gamma  (blk_gamma),
  .blk_delta  (blk_delta),
  .blk_scale  (blk_scale),
  .blk_exmax  (blk_exmax),
  .blk_cur_ge (blk_cur_ge)
);

// File: tb/bexp_assigner_test.sv
module bexp_assigner_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int N  = 4;
  localparam int L  = 4;
  localparam int EW = 4;
  localparam int HL = L - 1;
  localparam int SM = 2;
  localparam int NB = 11;

  // Stimulus: four input samples, one desired sample (offered with sample 1).
  localparam int TX [NB][4] = '{
    '{10, -20, 5, 3}, '{100, -3, 7, -50}, '{2, -1, 3, 1}, '{-128, 9, 0, 60},
    '{0, 0, 0, 0}, '{12, -9, 4, 1}, '{20, -30, 17, 2}, '{1, 0, 0, -1},
    '{70, 0, 0, -70}, '{3, 2, 1, -2}, '{5, 5, 5, 5}};
  localparam int TD  [NB] = '{40, 0, -6, 5, 0, 3, -1, 0, 0, 0, 0};
  // Expected: ex, gamma, delta, scale, cur_ge, exmax.
  localparam int EEX [NB] = '{-1, 0, -4, 1, -7, -3, -2, -6, 0, -5, -4};
  localparam int EGA [NB] = '{ 1, 2,  2, 3,  3, -1,  0,  0, 2,  2, -2};
  localparam int EDE [NB] = '{ 0, 1,  0, 1,  0, -4,  1,  0, 2,  0, -4};
  localparam int ESC [NB] = '{ 2, 2,  6, 2, 10,  2,  2,  6, 2,  7,  2};
  localparam int EGE [NB] = '{ 1, 1,  0, 1,  0,  1,  1,  0, 1,  0,  1};
  localparam int EMX [NB] = '{-1, 0,  0, 1,  1, -3, -2, -2, 0,  0, -4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] x_in = '0;
  logic signed [W-1:0] d_in = '0;
  logic blk_valid;
  logic signed [EW-1:0] blk_ex, blk_gamma, blk_exmax;
  logic signed [EW:0] blk_delta;
  logic [EW:0] blk_scale;
  logic blk_cur_ge;
  logic [HL*W-1:0] hist_filt, hist_upd;

  int n_checks = 0;
  int n_fail = 0;
  int prev_m [HL];

  always #(CLK_PERIOD/2) clk = ~clk;

  bexp_assigner #(.W(W), .N(N), .L(L), .EW(EW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
    .blk_valid(blk_valid), .blk_ex(blk_ex), .blk_gamma(blk_gamma),
    .blk_delta(blk_delta), .blk_scale(blk_scale), .blk_exmax(blk_exmax),
    .blk_cur_ge(blk_cur_ge), .hist_filt(hist_filt), .hist_upd(hist_upd));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Multiply by 2^-s with floor rounding (s may be negative).
  function automatic int scale_pow2(input int v, input int s);
    int d, q;
    if (s < 0) return v * (1 << (-s));
    d = 1 << s;
    q = v / d;
    if ((v % d != 0) && (v < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int field(input logic [HL*W-1:0] v, input int k);
    logic signed [W-1:0] f;
    f = v[k*W +: W];
    return int'(f);
  endfunction

  task automatic push(input int xv, input int dv);
    in_valid = 1'b1;
    x_in = W'(xv);
    d_in = W'(dv);
    @(negedge clk);
    in_valid = 1'b0;
    x_in = '0;
    d_in = '0;
  endtask

  task automatic check_block(input string tag, input int ex, input int ga, input int de,
                             input int sc, input int ge, input int mx);
    chk({tag, " R2 pulse"}, int'(blk_valid), 1);
    chk({tag, " R3 ex"}, int'(blk_ex), ex);
    chk({tag, " R5/R6 gamma"}, int'(blk_gamma), ga);
    chk({tag, " R7 delta"}, int'(blk_delta), de);
    chk({tag, " R5/R6 scale"}, int'(blk_scale), sc);
    chk({tag, " R5/R6 cur_ge"}, int'(blk_cur_ge), ge);
    chk({tag, " R6 exmax"}, int'(blk_exmax), mx);
    for (int k = 0; k < HL; k++) begin
      chk({tag, " R8 hist_filt"}, field(hist_filt, k), scale_pow2(prev_m[k], de));
      chk({tag, " R9 hist_upd"}, field(hist_upd, k), scale_pow2(prev_m[k], de - SM));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < HL; k++) prev_m[k] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    chk("R1 valid in reset", int'(blk_valid), 0);
    chk("R1 gamma in reset", int'(blk_gamma), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(blk_valid), 0);
    chk("R1 hist after reset", int'(hist_filt), 0);
    chk("R1 scale after reset", int'(blk_scale), 0);

    // Table walk, with idle gaps inside blocks (R2)
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < N; s++) begin
        if ((b + s) % 3 == 0) begin
          @(negedge clk);
          chk("R2 no pulse on idle", int'(blk_valid), 0);
        end
        push(TX[b][s], (s == 1) ? TD[b] : 0);
        if (s < N - 1) chk("R2 no pulse mid-block", int'(blk_valid), 0);
      end
      check_block($sformatf("blk%0d", b), EEX[b], EGA[b], EDE[b], ESC[b], EGE[b], EMX[b]);
      for (int k = 0; k < HL; k++) prev_m[k] = scale_pow2(TX[b][N-1-k], EGA[b]);
    end

    // R10: results hold over idle cycles
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 valid low", int'(blk_valid), 0);
      chk("R10 gamma held", int'(blk_gamma), EGA[NB-1]);
      chk("R10 delta held", int'(blk_delta), EDE[NB-1]);
    end

    // Reset mid-block, then the first block rule again (R4, R1)
    push(50, 0);
    push(-40, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears gamma", int'(blk_gamma), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < HL; k++) prev_m[k] = 0;
    push(64, 0);
    push(0, -2);
    push(0, 0);
    push(-3, 0);
    check_block("R4 first after reset", 0, 2, 0, 2, 1, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule